// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Parallel Bypass

This block holds the two character queues of a 16550-style UART: a receive queue whose entries carry a data byte plus three line-error flags, and a transmit queue of plain bytes. Software picks one of three buffering modes. The single-entry mode acts like a holding register, the standard mode gives sixteen entries, and the extended mode gives the full parameter depth. A receive trigger output tells the interrupt logic when enough characters have arrived, with the trigger levels scaled to the depth of the active mode.

In normal operation the serial receiver pushes characters into the receive queue and the serial transmitter pops bytes from the transmit queue. When bypass is selected, a parallel subsystem port takes over both of those roles. It writes bytes straight into the receive queue and reads bytes straight out of the transmit queue. The host side, the counts and the status flags behave the same in either mode.

Top module: `uart_fifo_pair`

## Requirements
- R1: After a synchronous reset, both counts are zero, both overrun flags are clear, both read-data outputs are zero, and the mode is single-entry.
- R2: Capacity follows `cfg_mode`: 0 gives 1 entry, 1 gives STD_DEPTH (16) entries, and 2 or 3 give DEPTH (64) entries. A push into a full queue is dropped and sets that queue's sticky overrun flag. The check for full uses the count before any pop in the same cycle.
- R3: A receive entry is 11 bits: [7:0] data, [8] parity error, [9] framing error, [10] break. `host_rd` on a non-empty receive queue puts the oldest entry on `host_rdata` one cycle later.
- R4: `host_wr` appends `host_wdata` to the transmit queue. A pop on a non-empty transmit queue puts the oldest byte on `tx_dout` one cycle later.
- R5: A read from an empty queue leaves its read-data output and its count unchanged.
- R6: With `cfg_bypass` high, `sub_wr` pushes `{3'b000, sub_wdata}` into the receive queue and `sub_rd` pops the transmit queue. `ser_rx_push` and `ser_tx_pop` are ignored.
- R7: With `cfg_bypass` low, `sub_wr` and `sub_rd` are ignored.
- R8: `rx_clr` / `tx_clr` empty the selected queue and clear its overrun flag at the next edge. The clear takes priority over a push or pop in the same cycle and leaves the other queue untouched.
- R9: Any change of the effective mode empties both queues and clears both overrun flags at the edge where the new mode is first seen.
- R10: `rx_trig` is high when the receive count is at least the selected level. For `rx_trig_sel` 0..3 the levels are 1, 4, 8, 14 in mode 1 and 1, 16, 32, 56 in extended mode. Mode 0 always uses level 1.
- R11: `rx_ready` is high exactly when the receive count is nonzero, and `tx_empty` is high exactly when the transmit count is zero, whatever the bypass setting.
- R12: A push and a pop on the same queue in the same cycle both take effect when the queue is neither empty nor full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Buffering mode: 0 single, 1 standard, 2/3 extended |
| cfg_bypass | input | 1 | Subsystem port replaces serial engines |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_clr | input | 1 | Empty receive queue |
| tx_clr | input | 1 | Empty transmit queue |
| ser_rx_push | input | 1 | Serial receiver push strobe |
| ser_rx_data | input | 8 | Serial received byte |
| ser_rx_flags | input | 3 | {break, framing, parity} error flags |
| ser_tx_pop | input | 1 | Serial transmitter pop strobe |
| sub_wr | input | 1 | Subsystem write strobe (bypass) |
| sub_wdata | input | 8 | Subsystem write byte |
| sub_rd | input | 1 | Subsystem read strobe (bypass) |
| host_wr | input | 1 | Host transmit write strobe |
| host_wdata | input | 8 | Host transmit byte |
| host_rd | input | 1 | Host receive read strobe |
| host_rdata | output | 11 | Receive entry read by host |
| tx_dout | output | 8 | Byte popped from transmit queue |
| rx_count | output | 7 | Receive queue fill count |
| tx_count | output | 7 | Transmit queue fill count |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_ready | output | 1 | Receive data available |
| tx_empty | output | 1 | Transmit queue empty |
| rx_trig | output | 1 | Receive count at or above trigger level |

## Verification
The bench builds the block with its default parameters, DEPTH 64 and STD_DEPTH 16. With these values, filling to the standard limit, the extended limit and one entry beyond each takes well under a hundred cycles. Random phases bias push against pop to drive both queues toward full and toward empty, and they step through every mode, bypass setting and trigger select. The trigger levels 14 and 56 are therefore crossed many times, and so are overruns, mode-change flushes and clears that collide with traffic.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [1:0] {
    FM_SINGLE = 2'd0,
    FM_STD    = 2'd1,
    FM_EXT    = 2'd2
  } fifo_mode_e;

  localparam int FLAG_W = 3;
  localparam int BYTE_W = 8;
  localparam int ENTRY_W = BYTE_W + FLAG_W;

  function automatic fifo_mode_e norm_mode(input logic [1:0] m);
    case (m)
      2'd0:    return FM_SINGLE;
      2'd1:    return FM_STD;
      default: return FM_EXT;
    endcase
  endfunction

endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CW-1:0]    cap,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             overrun
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty, do_push, do_pop, drop;

  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign drop    = push && full && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (do_pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (drop) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_trig.sv
module uart_rx_trig
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int STD_DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  fifo_mode_e    mode,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] count,
  output logic          trig
);

  localparam int STD_Q = STD_DEPTH / 4;
  localparam int STD_H = STD_DEPTH / 2;
  localparam int STD_T = STD_DEPTH - 2;
  localparam int EXT_Q = DEPTH / 4;
  localparam int EXT_H = DEPTH / 2;
  localparam int EXT_T = DEPTH - 8;

  logic [CW-1:0] level;

  always_comb begin
    level = CW'(1);
    if (mode == FM_STD) begin
      case (sel)
        2'd1: level = CW'(STD_Q);
        2'd2: level = CW'(STD_H);
        2'd3: level = CW'(STD_T);
        default: level = CW'(1);
      endcase
    end else if (mode == FM_EXT) begin
      case (sel)
        2'd1: level = CW'(EXT_Q);
        2'd2: level = CW'(EXT_H);
        2'd3: level = CW'(EXT_T);
        default: level = CW'(1);
      endcase
    end
  end

  assign trig = (count >= level);

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int STD_DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_bypass,
  input  logic [1:0]         rx_trig_sel,
  input  logic               rx_clr,
  input  logic               tx_clr,
  input  logic               ser_rx_push,
  input  logic [BYTE_W-1:0]  ser_rx_data,
  input  logic [FLAG_W-1:0]  ser_rx_flags,
  input  logic               ser_tx_pop,
  input  logic               sub_wr,
  input  logic [BYTE_W-1:0]  sub_wdata,
  input  logic               sub_rd,
  input  logic               host_wr,
  input  logic [BYTE_W-1:0]  host_wdata,
  input  logic               host_rd,
  output logic [ENTRY_W-1:0] host_rdata,
  output logic [BYTE_W-1:0]  tx_dout,
  output logic [CW-1:0]      rx_count,
  output logic [CW-1:0]      tx_count,
  output logic               rx_overrun,
  output logic               tx_overrun,
  output logic               rx_ready,
  output logic               tx_empty,
  output logic               rx_trig
);

  fifo_mode_e         mode_n, mode_q;
  logic               flush;
  logic [CW-1:0]      cap;
  logic               rx_push, tx_pop;
  logic [ENTRY_W-1:0] rx_din;

  assign mode_n = norm_mode(cfg_mode);
  assign flush  = (mode_n != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= FM_SINGLE;
    else     mode_q <= mode_n;
  end

  always_comb begin
    case (mode_n)
      FM_SINGLE: cap = CW'(1);
      FM_STD:    cap = CW'(STD_DEPTH);
      default:   cap = CW'(DEPTH);
    endcase
  end

  // source selection: subsystem port stands in for the serial engines
  assign rx_push = cfg_bypass ? sub_wr : ser_rx_push;
  assign rx_din  = cfg_bypass ? {{FLAG_W{1'b0}}, sub_wdata}
                              : {ser_rx_flags, ser_rx_data};
  assign tx_pop  = cfg_bypass ? sub_rd : ser_tx_pop;

  uart_sync_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr || flush), .cap(cap),
    .push(rx_push), .din(rx_din), .pop(host_rd),
    .dout(host_rdata), .count(rx_count), .overrun(rx_overrun)
  );

  uart_sync_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr || flush), .cap(cap),
    .push(host_wr), .din(host_wdata), .pop(tx_pop),
    .dout(tx_dout), .count(tx_count), .overrun(tx_overrun)
  );

  uart_rx_trig #(.DEPTH(DEPTH), .STD_DEPTH(STD_DEPTH)) u_trig (
    .mode(mode_n), .sel(rx_trig_sel), .count(rx_count), .trig(rx_trig)
  );

  assign rx_ready = (rx_count != '0);
  assign tx_empty = (tx_count == '0);

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int STD_DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         cfg_mode,
  input logic               cfg_bypass,
  input logic               rx_clr,
  input logic               tx_clr,
  input logic               ser_rx_push,
  input logic               sub_wr,
  input logic               host_wr,
  input logic               host_rd,
  input logic [ENTRY_W-1:0] host_rdata,
  input logic [CW-1:0]      rx_count,
  input logic [CW-1:0]      tx_count,
  input logic               flush
);

  function automatic int cap_of(input logic [1:0] m);
    case (m)
      2'd0:    return 1;
      2'd1:    return STD_DEPTH;
      default: return DEPTH;
    endcase
  endfunction

  p_count_cap_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(rx_count) <= cap_of($past(cfg_mode))) && (int'(tx_count) <= cap_of($past(cfg_mode))));

  p_tx_push_r4: assert property (@(posedge clk) disable iff (rst)
    (host_wr && tx_count == '0 && !tx_clr && !flush) |=> (tx_count == CW'(1)));

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rd && rx_count == '0) |=> $stable(host_rdata));

  p_sub_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_bypass && sub_wr && !ser_rx_push && !host_rd && !rx_clr && !flush) |=> $stable(rx_count));

  p_clr_empties_r8: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> (rx_count == '0));

  p_mode_flush_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rx_count == '0 && tx_count == '0));

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH), .STD_DEPTH(STD_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_bypass(cfg_bypass),
  .rx_clr(rx_clr), .tx_clr(tx_clr), .ser_rx_push(ser_rx_push), .sub_wr(sub_wr),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
  .rx_count(rx_count), .tx_count(tx_count), .flush(flush)
);

// File: tb/uart_fifo_pair_bench.sv
`timescale 1ns/1ps
module uart_fifo_pair_bench;

  localparam int DEP = 64;
  localparam int STD = 16;
  localparam int CW  = $clog2(DEP) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0, rx_trig_sel = 2'd0;
  logic cfg_bypass = 0, rx_clr = 0, tx_clr = 0, ser_rx_push = 0, ser_tx_pop = 0;
  logic sub_wr = 0, sub_rd = 0, host_wr = 0, host_rd = 0;
  logic [7:0] ser_rx_data = 0, sub_wdata = 0, host_wdata = 0;
  logic [2:0] ser_rx_flags = 0;
  logic [10:0] host_rdata;
  logic [7:0]  tx_dout;
  logic [CW-1:0] rx_count, tx_count;
  logic rx_overrun, tx_overrun, rx_ready, tx_empty, rx_trig;

  always #2.5 clk = ~clk;

  uart_fifo_pair #(.DEPTH(DEP), .STD_DEPTH(STD)) u_uart_fifo_pair (.*);

  int total = 0, bad = 0;
  logic [10:0] rxq[$];
  logic [7:0]  txq[$];
  logic [10:0] last_rx = 0;
  logic [7:0]  last_tx = 0;
  bit rxo = 0, txo = 0;
  int mq = 0;

  function automatic int norm(input logic [1:0] m);
    return (m == 2'd0) ? 0 : (m == 2'd1) ? 1 : 2;
  endfunction

  function automatic int level(input int m, input logic [1:0] s);
    if (m == 1) return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    if (m == 2) return (s == 0) ? 1 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
    return 1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int m, cap;
    bit chg, full, pe, push;
    logic [10:0] din;
    m = norm(cfg_mode);
    chg = (m != mq);
    mq = m;
    cap = (m == 0) ? 1 : (m == 1) ? STD : DEP;
    push = cfg_bypass ? sub_wr : ser_rx_push;
    din  = cfg_bypass ? {3'b000, sub_wdata} : {ser_rx_flags, ser_rx_data};
    if (rx_clr || chg) begin rxq.delete(); rxo = 0; end
    else begin
      full = rxq.size() >= cap; pe = rxq.size() > 0;
      if (host_rd && pe) last_rx = rxq.pop_front();
      if (push) begin if (full) rxo = 1; else rxq.push_back(din); end
    end
    push = cfg_bypass ? sub_rd : ser_tx_pop;
    if (tx_clr || chg) begin txq.delete(); txo = 0; end
    else begin
      full = txq.size() >= cap; pe = txq.size() > 0;
      if (push && pe) last_tx = txq.pop_front();
      if (host_wr) begin if (full) txo = 1; else txq.push_back(host_wdata); end
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rx_count", int'(rx_count), rxq.size());
    chk(tag, "tx_count", int'(tx_count), txq.size());
    chk(tag, "host_rdata", int'(host_rdata), int'(last_rx));
    chk(tag, "tx_dout", int'(tx_dout), int'(last_tx));
    chk(tag, "rx_overrun", int'(rx_overrun), int'(rxo));
    chk(tag, "tx_overrun", int'(tx_overrun), int'(txo));
    chk(tag, "rx_ready R11", int'(rx_ready), int'(rxq.size() != 0));
    chk(tag, "tx_empty R11", int'(tx_empty), int'(txq.size() == 0));
    chk(tag, "rx_trig R10", int'(rx_trig), int'(rxq.size() >= level(mq, rx_trig_sel)));
  endtask

  task automatic cycle(input string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    {rx_clr, tx_clr, ser_rx_push, ser_tx_pop, sub_wr, sub_rd, host_wr, host_rd} = '0;
  endtask

  task automatic phase(input string tag, input logic [1:0] md, input bit byp,
                       input int push_pct, input int pop_pct, input int n);
    cfg_mode = md; cfg_bypass = byp;
    for (int i = 0; i < n; i++) begin
      ser_rx_push  = ($urandom % 100) < push_pct;
      sub_wr       = ($urandom % 100) < push_pct;
      host_wr      = ($urandom % 100) < push_pct;
      host_rd      = ($urandom % 100) < pop_pct;
      ser_tx_pop   = ($urandom % 100) < pop_pct;
      sub_rd       = ($urandom % 100) < pop_pct;
      rx_clr       = ($urandom % 100) < 2;
      tx_clr       = ($urandom % 100) < 2;
      ser_rx_data  = 8'($urandom); ser_rx_flags = 3'($urandom);
      sub_wdata    = 8'($urandom); host_wdata = 8'($urandom);
      if (($urandom % 16) == 0) rx_trig_sel = 2'($urandom);
      cycle(tag);
    end
    idle();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1");

    // R2: fill standard mode past its limit
    cfg_mode = 2'd1; cycle("R9");
    ser_rx_push = 1; host_wr = 1;
    for (int i = 0; i < STD + 2; i++) begin
      ser_rx_data = 8'(i); ser_rx_flags = 3'(i); host_wdata = 8'(8'hA0 + i);
      cycle("R2");
    end
    idle();
    // R12: push and pop together on a partly full queue
    host_rd = 1; cycle("R3"); ser_rx_push = 1; ser_rx_data = 8'h5C; cycle("R12"); idle();
    // R8: clear with a simultaneous push, transmit side untouched
    rx_clr = 1; ser_rx_push = 1; cycle("R8"); idle(); cycle("R8");
    // R5: reads on empty receive queue, pops on empty transmit drained queue
    host_rd = 1; repeat (3) cycle("R5"); idle();
    ser_tx_pop = 1; repeat (STD + 3) cycle("R5"); idle();
    // R7: subsystem strobes ignored without bypass
    sub_wr = 1; sub_wdata = 8'h77; host_wr = 1; host_wdata = 8'h31; cycle("R7");
    host_wr = 0; sub_rd = 1; cycle("R7"); idle();
    // R6: bypass with serial strobes also active
    cfg_bypass = 1;
    sub_wr = 1; sub_wdata = 8'hC3; ser_rx_push = 1; ser_rx_data = 8'h11; ser_rx_flags = 3'b111;
    cycle("R6"); idle();
    host_rd = 1; cycle("R6"); idle();
    ser_tx_pop = 1; cycle("R6"); idle();
    sub_rd = 1; cycle("R6"); idle();
    cfg_bypass = 0;
    // R10/R2: extended fill to the top with every trigger select
    cfg_mode = 2'd2; cycle("R9");
    ser_rx_push = 1; host_wr = 1;
    for (int i = 0; i < DEP + 2; i++) begin
      ser_rx_data = 8'($urandom); rx_trig_sel = 2'(i % 4);
      cycle("R10");
    end
    idle();
    // R9: mode change flushes both
    cfg_mode = 2'd3; cycle("R9");
    cfg_mode = 2'd0; cycle("R9");
    // random phases
    for (int r = 0; r < 6; r++) begin
      phase("R3", 2'(r % 4), r[0], 50, 40, 200);
      phase("R4", 2'(r % 4), ~r[0], 90, 10, 120);
      phase("R11", 2'(r % 4), r[1], 10, 90, 120);
      phase("R12", 2'($urandom), 1'($urandom), 60, 60, 150);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule